// File: doc/BRIEF.md
# Single-Step Signal Capture Framer

This block is debug logic for watching a synchronous circuit one clock cycle at a time. It generates the observed circuit's clock itself, one pulse per step. After each pulse it waits a fixed number of system clocks so that the observed signals can settle. It then snapshots a memory-interface signal group: the command triple, address, bank, mask, data-drive flag, controller status and host strobes.

The snapshot is packed into four payload bytes. A frame is then formed from a fixed two-byte marker, a rolling 8-bit frame number and those four payload bytes. The seven bytes go out through a byte-wide valid/ready interface, which would normally feed a UART transmitter. The next pulse is issued only after the last byte of the frame has been accepted. Every observed cycle therefore reaches the host, however slow the link is, and a gap in the frame numbers shows that a frame was lost. A run input pauses stepping at a frame boundary.

Top module: `sig_step_packer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `step_clk` and `tx_valid` are low. The frame number of the first frame after reset is 0.
- R2: A frame is exactly seven bytes in this order: 0xAA, 0x55, frame number, payload 0, payload 1, payload 2, payload 3.
- R3: The frame number goes up by one for each frame sent and wraps from 255 to 0.
- R4: Payload 0 holds the command {ras_n, cas_n, we_n} in bits [2:0], the mask in bit 3 and the data-drive flag in bit 4. Bits [7:5] are 0.
- R5: Payload 1 is address[7:0]. Payload 2 holds address[11:8] in bits [3:0], 0 in bits [5:4] and the bank in bits [7:6].
- R6: Payload 3 holds wr_n in bit 0, rd_n in bit 1, write-ack in bit 2, read-valid in bit 3 and busy_n in bit 4. Bits [7:5] are 0.
- R7: A byte is handed over only when `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R8: Each `step_clk` pulse lasts exactly one clock. No pulse occurs while a frame is being sent. A new pulse follows only after the last byte of the previous frame has been accepted.
- R9: The payload reflects the observed signals as they stand `SETTLE_CYCLES` clocks after the pulse. Changes to those signals while the frame is being sent do not alter it.
- R10: With `run` low, no new pulse starts. A frame already in progress is still completed in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Stepping enable |
| step_clk | output | 1 | Generated clock pulse for the observed circuit |
| mon_cmd | input | 3 | Observed command {ras_n, cas_n, we_n} |
| mon_addr | input | 12 | Observed address |
| mon_bank | input | 2 | Observed bank select |
| mon_dqm | input | 1 | Observed data mask |
| mon_dqdrive | input | 1 | Observed data-drive flag |
| mon_busy_n | input | 1 | Observed controller busy (active low) |
| mon_rd_valid | input | 1 | Observed read-valid strobe |
| mon_wrd_ack | input | 1 | Observed write-ack strobe |
| mon_rd_n | input | 1 | Observed host read request (active low) |
| mon_wr_n | input | 1 | Observed host write request (active low) |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_ready | input | 1 | Transmitter accepts a byte |

## Verification
Two events can fall in the same cycle: acceptance of a frame's last byte, and the end of that frame, which advances the frame number and lets the block start a new step. A phase that holds `tx_ready` constantly high forces this, so each frame ends in the very cycle of its last handshake. It is judged by requiring the next frame to carry exactly the next number, and by checking that no pulse appeared while any expected byte was still outstanding. A second case drops `run` in the middle of a frame, and is judged by requiring the remaining bytes to complete while the pulse count stays frozen.

// File: rtl/sig_step_packer.sv
module sig_step_packer #(
  parameter logic [7:0] SYNC_HI       = 8'hAA,
  parameter logic [7:0] SYNC_LO       = 8'h55,
  parameter int         SETTLE_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  output logic        step_clk,
  input  logic [2:0]  mon_cmd,
  input  logic [11:0] mon_addr,
  input  logic [1:0]  mon_bank,
  input  logic        mon_dqm,
  input  logic        mon_dqdrive,
  input  logic        mon_busy_n,
  input  logic        mon_rd_valid,
  input  logic        mon_wrd_ack,
  input  logic        mon_rd_n,
  input  logic        mon_wr_n,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready
);
  localparam int FRAME_BYTES = 7;
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam int WAIT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);
  localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_HIGH, S_SETTLE, S_SEND} st_t;

  st_t              st;
  logic             step_q;
  logic [WAIT_W-1:0] wait_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       seq_q;
  logic [7:0]       pb0, pb1, pb2, pb3;

  assign step_clk = step_q;
  assign tx_valid = (st == S_SEND);

  always_comb begin
    case (idx_q)
      3'd0:    tx_data = SYNC_HI;
      3'd1:    tx_data = SYNC_LO;
      3'd2:    tx_data = seq_q;
      3'd3:    tx_data = pb0;
      3'd4:    tx_data = pb1;
      3'd5:    tx_data = pb2;
      default: tx_data = pb3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step_q <= 1'b0;
      wait_q <= '0;
      idx_q  <= '0;
      seq_q  <= '0;
      pb0    <= '0;
      pb1    <= '0;
      pb2    <= '0;
      pb3    <= '0;
    end else begin
      case (st)
        S_IDLE: if (run) begin
          st     <= S_HIGH;
          step_q <= 1'b1;
        end
        S_HIGH: begin
          step_q <= 1'b0;
          wait_q <= '0;
          st     <= S_SETTLE;
        end
        S_SETTLE: if (wait_q == WAIT_END) begin
          pb0   <= {3'b000, mon_dqdrive, mon_dqm, mon_cmd};
          pb1   <= mon_addr[7:0];
          pb2   <= {mon_bank, 2'b00, mon_addr[11:8]};
          pb3   <= {3'b000, mon_busy_n, mon_rd_valid, mon_wrd_ack, mon_rd_n, mon_wr_n};
          idx_q <= '0;
          st    <= S_SEND;
        end else begin
          wait_q <= wait_q + 1'b1;
        end
        default: if (tx_ready) begin
          if (idx_q == LAST_IDX) begin
            seq_q <= seq_q + 8'd1;
            st    <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sig_step_packer_chk.sv
module sig_step_packer_chk #(
  parameter logic [7:0] SYNC_HI = 8'hAA
) (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       step_clk,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic [7:0] seq_q
);
  p_no_step_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_clk |-> !tx_valid);
  p_step_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_clk |=> !step_clk);
  p_hold_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_sync_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> (tx_data == SYNC_HI));
  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seq_q) |-> (seq_q == $past(seq_q) + 8'd1));
  p_run_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_clk) |-> $past(run));
endmodule

bind sig_step_packer sig_step_packer_chk #(.SYNC_HI(SYNC_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .step_clk(step_clk),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .seq_q(seq_q)
);

// File: tb/test_sig_step_packer.sv
module test_sig_step_packer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic step_clk;
  logic [2:0] mon_cmd = '0;
  logic [11:0] mon_addr = '0;
  logic [1:0] mon_bank = '0;
  logic mon_dqm = 0, mon_dqdrive = 0, mon_busy_n = 0, mon_rd_valid = 0;
  logic mon_wrd_ack = 0, mon_rd_n = 0, mon_wr_n = 0;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_ready = 1'b0;

  int checks = 0, errors = 0, pulses = 0, frames_done = 0;
  int rdy_mode = 0;
  logic [7:0] exp_seq = 8'd0;
  logic [7:0] exp_q[$];
  int tag_q[$];
  logic stall_prev = 0;
  logic [7:0] data_prev = 0;
  logic step_prev = 0;

  always #2 clk = ~clk;

  sig_step_packer i_sig_step_packer (
    .clk(clk), .rst_n(rst_n), .run(run), .step_clk(step_clk),
    .mon_cmd(mon_cmd), .mon_addr(mon_addr), .mon_bank(mon_bank),
    .mon_dqm(mon_dqm), .mon_dqdrive(mon_dqdrive), .mon_busy_n(mon_busy_n),
    .mon_rd_valid(mon_rd_valid), .mon_wrd_ack(mon_wrd_ack),
    .mon_rd_n(mon_rd_n), .mon_wr_n(mon_wr_n),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  function automatic string req_of(int b);
    case (b)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rdy_mode == 1) tx_ready = 1'b1;
    else tx_ready = ($urandom % 3) != 0;
  end

  // driver: model of the observed circuit, pushes the expected frame per pulse
  initial begin
    forever begin
      @(posedge step_clk);
      pulses++;
      check(exp_q.size() == 0, "R8", exp_q.size(), 0);
      mon_cmd = 3'($urandom); mon_addr = 12'($urandom); mon_bank = 2'($urandom);
      mon_dqm = 1'($urandom); mon_dqdrive = 1'($urandom); mon_busy_n = 1'($urandom);
      mon_rd_valid = 1'($urandom); mon_wrd_ack = 1'($urandom);
      mon_rd_n = 1'($urandom); mon_wr_n = 1'($urandom);
      exp_q.push_back(8'hAA); exp_q.push_back(8'h55); exp_q.push_back(exp_seq);
      exp_q.push_back({3'b000, mon_dqdrive, mon_dqm, mon_cmd});
      exp_q.push_back(mon_addr[7:0]);
      exp_q.push_back({mon_bank, 2'b00, mon_addr[11:8]});
      exp_q.push_back({3'b000, mon_busy_n, mon_rd_valid, mon_wrd_ack, mon_rd_n, mon_wr_n});
      for (int b = 0; b < 7; b++) tag_q.push_back(b);
      exp_seq = exp_seq + 8'd1;
      @(posedge tx_valid);
      #1;
      // R9: disturb the observed signals after sampling
      mon_cmd = ~mon_cmd; mon_addr = ~mon_addr; mon_bank = ~mon_bank;
      mon_dqm = ~mon_dqm; mon_dqdrive = ~mon_dqdrive; mon_busy_n = ~mon_busy_n;
      mon_rd_valid = ~mon_rd_valid; mon_wrd_ack = ~mon_wrd_ack;
      mon_rd_n = ~mon_rd_n; mon_wr_n = ~mon_wr_n;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (step_clk && step_prev) check(0, "R8", 1, 0);
      if (step_clk) check(!tx_valid, "R8", tx_valid, 0);
      if (stall_prev) check(tx_valid && tx_data == data_prev, "R7", tx_data, data_prev);
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) check(0, "R10", tx_data, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic int t = tag_q.pop_front();
          check(tx_data == e, (t >= 3) ? {req_of(t), "/R9"} : req_of(t), tx_data, e);
          if (t == 6) frames_done++;
        end
      end
      stall_prev = tx_valid && !tx_ready;
      data_prev = tx_data;
      step_prev = step_clk;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!step_clk && !tx_valid, "R1", {step_clk, tx_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!step_clk && !tx_valid, "R1", {step_clk, tx_valid}, 0);
    run = 1'b1;
    wait (frames_done >= 100);
    rdy_mode = 1;
    wait (frames_done >= 130);
    rdy_mode = 0;
    // R10: stop in the middle of a frame
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    run = 1'b0;
    begin
      int p0;
      p0 = pulses;
      repeat (80) @(negedge clk);
      check(exp_q.size() == 0, "R10", exp_q.size(), 0);
      check(pulses == p0 && !tx_valid, "R10", pulses, p0);
    end
    run = 1'b1;
    wait (frames_done >= 300);
    @(negedge clk);
    run = 1'b0;
    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    check(frames_done == pulses, "R8", frames_done, pulses);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule